// File: doc/BRIEF.md
# Refresh Interval Request Generator

This block paces DRAM refresh. A free-running down-counter, clocked on the rising edge of the system clock, counts toward a programmable threshold. When the count equals the threshold, the counter jumps back to its top value (255 with the default 8-bit width) and a refresh-request flag is raised for the DRAM sequencer. The flag stays up until the sequencer answers on two separate acknowledge lines, and both lines must be seen active on the same clock edge. The counter runs the whole time, so each interval is measured from the previous reload and not from the acknowledge.

The request is held by a two-state machine. `ST_IDLE` means no refresh is owed and `ST_PEND` means one is owed. Three transitions are named:
- IDLE->PEND on a threshold hit.
- PEND->IDLE when both acknowledges are high and there is no hit.
- PEND->PEND otherwise.

A hit always wins over an acknowledge. A hit that arrives while a request is already pending does not queue a second one. The current count is brought out for debug.

Top module: `rfsh_interval_gen`

## Requirements
- R1: While `rst` is high at a rising edge, the count loads 255 and `rfsh_req` becomes 0.
- R2: When the count differs from `thresh`, each rising edge lowers the count by exactly one.
- R3: When the count equals `thresh` at a rising edge, that edge loads 255 into the count and sets `rfsh_req` to 1.
- R4: A pending request is cleared by the first edge at which `ack_a` and `ack_b` are both 1 and there is no threshold hit.
- R5: With only one of `ack_a` or `ack_b` high, a pending request stays at 1.
- R6: The count keeps stepping while a request is pending, whatever the acknowledges do.
- R7: A threshold hit while a request is pending keeps `rfsh_req` at 1 and queues nothing, so one later dual acknowledge clears it.
- R8: A threshold hit on the same edge as a dual acknowledge leaves `rfsh_req` at 1.
- R9: Acknowledges held for several cycles, or given while no request is pending, cause no spurious request and do not disturb the count.
- R10: If `thresh` is above the current count, the count steps down modulo 256 through 0 and 255 until it meets `thresh`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| thresh | input | 8 | Threshold count at which a refresh is requested |
| ack_a | input | 1 | First refresh acknowledge, active high |
| ack_b | input | 1 | Second refresh acknowledge, active high |
| rfsh_req | output | 1 | Registered refresh request |
| dbg_count | output | 8 | Current interval count, for debug |

## Verification
The hardest case to reach is a threshold hit landing on exactly the edge where both acknowledges are high (R8). Random acknowledges meet it only rarely. A directed step therefore watches `dbg_count`. At the falling edge where it equals `thresh`, the step raises both acknowledges, so the next rising edge carries both the hit and the dual acknowledge. A second directed step moves `thresh` above the count to force the modulo wrap. A long random run then mixes thresholds and acknowledge patterns and compares every cycle against a bench model.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_PEND = 1'b1
    } req_state_t;
endpackage

// File: rtl/rfsh_down_counter.sv
module rfsh_down_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] thresh,
    output logic [CNT_W-1:0] cnt,
    output logic             hit
);
    localparam logic [CNT_W-1:0] RELOAD = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] ONE    = CNT_W'(1);

    assign hit = (cnt == thresh);

    always_ff @(posedge clk) begin
        if (rst)      cnt <= RELOAD;
        else if (hit) cnt <= RELOAD;
        else          cnt <= cnt - ONE;
    end

    // R3: a hit reloads the top value
    p_reload_r3: assert property (@(posedge clk) disable iff (rst)
        hit |=> (cnt == RELOAD));

    // R2, R10: otherwise one step down, modulo width
    p_step_r2: assert property (@(posedge clk) disable iff (rst)
        !hit |=> (cnt == CNT_W'($past(cnt) - ONE)));
endmodule

// File: rtl/rfsh_req_fsm.sv
module rfsh_req_fsm
    import rfsh_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic hit,
    input  logic ack_a,
    input  logic ack_b,
    output logic req
);
    req_state_t state_q, state_d;
    logic       ack_both;

    assign ack_both = ack_a & ack_b;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (hit)                   state_d = ST_PEND;
            ST_PEND: if (ack_both && !hit)      state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        req = (state_q == ST_PEND);
    end

    // R3, R7, R8: a hit always leaves the request set
    p_hit_sets_r3: assert property (@(posedge clk) disable iff (rst)
        hit |=> req);

    // R5: no dual acknowledge, pending stays pending
    p_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (req && !(ack_a && ack_b)) |=> req);

    // R4: dual acknowledge without hit clears
    p_clear_r4: assert property (@(posedge clk) disable iff (rst)
        (req && ack_a && ack_b && !hit) |=> !req);

    // R9: nothing but a hit raises the request
    p_no_spurious_r9: assert property (@(posedge clk) disable iff (rst)
        (!req && !hit) |=> !req);
endmodule

// File: rtl/rfsh_interval_gen.sv
module rfsh_interval_gen #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] thresh,
    input  logic             ack_a,
    input  logic             ack_b,
    output logic             rfsh_req,
    output logic [CNT_W-1:0] dbg_count
);
    logic hit;

    rfsh_down_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .thresh (thresh),
        .cnt    (dbg_count),
        .hit    (hit)
    );

    rfsh_req_fsm u_fsm (
        .clk   (clk),
        .rst   (rst),
        .hit   (hit),
        .ack_a (ack_a),
        .ack_b (ack_b),
        .req   (rfsh_req)
    );

    // R1: reset leaves the request low
    p_reset_r1: assert property (@(posedge clk)
        rst |=> !rfsh_req);
endmodule

// File: tb/rfsh_interval_gen_bench.sv
module rfsh_interval_gen_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] thresh = 8'd250;
    logic       ack_a = 1'b0;
    logic       ack_b = 1'b0;
    logic       rfsh_req;
    logic [7:0] dbg_count;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    bit chk_en = 1'b0;

    logic [7:0] m_cnt = 8'd255;
    logic       m_req = 1'b0;
    string      tag_c = "R1";
    string      tag_r = "R1";

    always #2.5 clk = ~clk;

    rfsh_interval_gen u_rfsh_interval_gen (
        .clk(clk), .rst(rst), .thresh(thresh),
        .ack_a(ack_a), .ack_b(ack_b),
        .rfsh_req(rfsh_req), .dbg_count(dbg_count)
    );

    function automatic logic [7:0] f_cnt_next(logic [7:0] c, logic [7:0] t);
        return (c == t) ? 8'd255 : c - 8'd1;
    endfunction

    function automatic logic f_req_next(logic r, logic h, logic a, logic b);
        if (h) return 1'b1;
        if (r && a && b) return 1'b0;
        return r;
    endfunction

    task automatic chk(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // model, updated on the rising edge from the requirements
    always @(posedge clk) begin
        logic h;
        logic both;
        if (rst) begin
            m_cnt = 8'd255;
            m_req = 1'b0;
            tag_c = "R1";
            tag_r = "R1";
        end else begin
            h    = (m_cnt == thresh);
            both = ack_a && ack_b;
            if (h)                  tag_c = "R3";
            else if (thresh > m_cnt) tag_c = "R10";
            else if (m_req)         tag_c = "R6";
            else                    tag_c = "R2";
            if (h && both)                    tag_r = "R8";
            else if (h && m_req)              tag_r = "R7";
            else if (h)                       tag_r = "R3";
            else if (m_req && both)           tag_r = "R4";
            else if (m_req && (ack_a || ack_b)) tag_r = "R5";
            else if (m_req)                   tag_r = "R6";
            else                              tag_r = "R9";
            m_req = f_req_next(m_req, h, ack_a, ack_b);
            m_cnt = f_cnt_next(m_cnt, thresh);
        end
    end

    always @(negedge clk) begin
        if (chk_en) begin
            chk(tag_c, int'(dbg_count), int'(m_cnt));
            chk(tag_r, int'(rfsh_req), int'(m_req));
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk("R1", int'(dbg_count), 255);
        chk("R1", int'(rfsh_req), 0);
        rst = 1'b0;
        chk_en = 1'b1;

        // R3, R7: first hit, then a second hit while pending
        repeat (20) @(negedge clk);
        // R5: single acknowledges
        ack_a = 1'b1; repeat (3) @(negedge clk);
        ack_a = 1'b0; ack_b = 1'b1; repeat (3) @(negedge clk);
        // R4, R9: dual acknowledge held four cycles
        ack_a = 1'b1; repeat (4) @(negedge clk);
        ack_a = 1'b0; ack_b = 1'b0;
        repeat (3) @(negedge clk);

        // R8: dual acknowledge on the hit edge
        for (int k = 0; k < 3; k++) begin
            while (dbg_count != thresh) @(negedge clk);
            ack_a = 1'b1; ack_b = 1'b1;
            @(negedge clk);
            ack_a = 1'b0; ack_b = 1'b0;
            @(negedge clk);
        end

        // R10: threshold above the count forces a wrap
        thresh = 8'd0;
        while (dbg_count != 8'd100) @(negedge clk);
        thresh = 8'd200;
        repeat (400) @(negedge clk);

        // random mix
        for (int i = 0; i < 6000; i++) begin
            if ($urandom_range(0, 299) == 0)
                thresh = 8'($urandom_range(180, 255));
            ack_a = ($urandom_range(0, 3) == 0);
            ack_b = ($urandom_range(0, 3) == 0);
            @(negedge clk);
        end
        ack_a = 1'b0; ack_b = 1'b0;
        @(negedge clk);
        chk_en = 1'b0;
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #500000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule